// File: doc/BRIEF.md
# Dual-Channel Storage Controller Register Block

This block is the memory-mapped register file of a two-channel disk controller. A host reaches it through a simple single-cycle bus made of an address, an access size, read and write strobes, write data and registered read data. Each channel keeps a DMA command byte, a DMA status byte, a 32-bit descriptor pointer, a six-bit scratch byte, a 12-bit link control register and a 16-bit interrupt-enable register. It also has a read-only configuration word. Some per-channel registers answer at more than one offset.

Two summary words pack command, status and pending-interrupt bits from both channels into one read. A single interrupt line is raised while either channel has an interrupt pending. Writing a link control value with bit 0 set sends a one-clock reset pulse to that channel's device bus. Task-file data and control accesses are not stored here. They are decoded into select strobes and a register index for the external device logic, and the read data that logic returns is passed through.

Top module: `stor_regblock`

## Requirements
- R1: After reset the command, scratch, status, pointer, link control and interrupt-enable registers read zero. The configuration words read 0x65150000, read data is zero, and irq_out and chan_reset are low.
- R2: The command byte of channel 0 is written at 0x00 or 0x10 and the command byte of channel 1 at 0x08 or 0x18. Each is read back in bits 7:0 at 0x00 and 0x08.
- R3: The scratch byte of channel 0 is written at 0x01 or 0x11 and that of channel 1 at 0x09 or 0x19. Only the written bits 5:0 are kept, and the byte reads back zero-extended at 0x01 and 0x09.
- R4: Status is written at 0x02/0x12 (channel 0) or 0x0A/0x1A (channel 1) and read at 0x02/0x0A. A write loads bits 6:5, clears bit 1 and bit 2 wherever a one is written, and leaves bits 7, 4 and 3 at zero. Bit 0 is read-only and shows dma_active one clock late. A pulse on dma_err_set sets bit 1 and a pulse on dma_int_set sets bit 2, and a set wins over a clear in the same cycle.
- R5: The descriptor pointer sits at 0x04-0x07 (channel 0) and 0x0C-0x0F (channel 1). bus_size is 0 for a byte, 1 for a halfword and 2 or 3 for a word. A write of size s at byte k loads bytes k and up from the low write-data bytes. A read at byte k returns the pointer shifted right by 8*k.
- R6: Link control at 0x100/0x180 keeps the written bits 11:0. A write with bit 0 set drives chan_reset of that channel high for exactly the clock after the write edge.
- R7: Interrupt enable at 0x148/0x1C8 stores write-data bits 31:16 ANDed with 0x3EED, and reads back in bits 31:16.
- R8: The configuration word at 0xA0/0xE0 reads 0x6515 in bits 31:16, with bit 11 set to that channel's chan_irq as registered one clock earlier and all other bits zero. Writes to it are ignored.
- R9: A read at 0x10 returns channel-1 status in 31:24 and channel-0 status in 23:16. Bit 14 holds channel-1 status bit 2, and bits 7:0 hold the channel-0 command ORed with pending 0 in bit 4 and pending 1 in bit 6.
- R10: A read at 0x18 returns channel-1 status in bits 23:16 and, in bits 7:0, the channel-1 command with bit 4 ORed with pending 1.
- R11: irq_out is the OR of both channels' registered pending bits.
- R12: A read at 0x104/0x184 returns 0x113 while dev_present of that channel is high and 0 otherwise.
- R13: Any other offset, including 0x03, 0x0B and reads of 0x11, reads zero. Writes to such offsets change no register.
- R14: Offsets 0x80-0x87/0xC0-0xC7 raise tf_data_sel and offsets 0x8A/0xCA raise tf_ctl_sel, bit 0 for channel 0 and bit 1 for channel 1, in the same cycle as the strobe. tf_idx carries the register index (address bits 2:0, or 2 for control), tf_wr marks a write, and reads there return tf_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the clock after the read strobe |
| dma_active | input | 2 | Per-channel engine busy level |
| dma_err_set | input | 2 | Per-channel error set pulse |
| dma_int_set | input | 2 | Per-channel completion interrupt set pulse |
| chan_irq | input | 2 | Per-channel device interrupt level |
| dev_present | input | 2 | Per-channel device-attached flag |
| tf_rdata | input | 32 | Read data from the external task-file logic |
| tf_data_sel | output | 2 | Task-file data select per channel |
| tf_ctl_sel | output | 2 | Task-file control select per channel |
| tf_idx | output | 3 | Task-file register index |
| tf_wr | output | 1 | Task-file access is a write |
| chan_reset | output | 2 | One-clock device-bus reset pulse per channel |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The hardest state to reach from the ports is a status write and a hardware set pulse landing on the same bit at the same clock edge. The bench drives dma_int_set and the status write in the same cycle, then reads the status back to show that the set wins. The summary words also need mixed state in both channels at once, so the bench first builds distinct command and status values and pending interrupts on both channels. Only then does it read both summaries and compare them with values it assembles from the requirements.

// File: rtl/stor_regblock_pkg.sv
package stor_regblock_pkg;

  localparam int          NUM_CH       = 2;
  localparam int          VDATA_W      = 6;
  localparam int          SCTL_W       = 12;
  localparam int          IEN_W        = 16;
  localparam logic [15:0] CONF_ID      = 16'h6515;
  localparam logic [15:0] IEN_MASK     = 16'h3EED;
  localparam logic [31:0] DEV_PRES_VAL = 32'h0000_0113;

  typedef enum logic [3:0] {
    K_NONE, K_CMD, K_VDATA, K_STAT, K_PTR, K_SUM, K_CONF,
    K_SCTL, K_DEVST, K_IEN, K_TFDATA, K_TFCTL
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic       ch;
    logic [2:0] sub;
  } reg_sel_t;

  // Map a 9-bit byte offset to a register kind, channel and sub-index.
  // Aliases at 0x1x are write-only except the summary word.
  function automatic reg_sel_t decode_addr(input logic [8:0] a, input logic is_wr);
    reg_sel_t s;
    s.kind = K_NONE;
    s.ch   = 1'b0;
    s.sub  = 3'd0;
    if (a[8:5] == 4'b0000) begin
      s.ch = a[3];
      if (!a[4]) begin
        case (a[2:0])
          3'd0:    s.kind = K_CMD;
          3'd1:    s.kind = K_VDATA;
          3'd2:    s.kind = K_STAT;
          3'd3:    s.kind = K_NONE;
          default: begin
            s.kind = K_PTR;
            s.sub  = {1'b0, a[1:0]};
          end
        endcase
      end else begin
        case (a[2:0])
          3'd0:    s.kind = is_wr ? K_CMD : K_SUM;
          3'd1:    s.kind = is_wr ? K_VDATA : K_NONE;
          3'd2:    s.kind = is_wr ? K_STAT : K_NONE;
          default: s.kind = K_NONE;
        endcase
      end
    end else if (a[8:7] == 2'b01) begin
      s.ch = a[6];
      if (a[5:3] == 3'b000) begin
        s.kind = K_TFDATA;
        s.sub  = a[2:0];
      end else if (a[5:0] == 6'h0A) begin
        s.kind = K_TFCTL;
        s.sub  = 3'd2;
      end else if (a[5:0] == 6'h20 && !is_wr) begin
        s.kind = K_CONF;
      end
    end else if (a[8]) begin
      s.ch = a[7];
      case (a[6:0])
        7'h00:   s.kind = K_SCTL;
        7'h04:   s.kind = is_wr ? K_NONE : K_DEVST;
        7'h48:   s.kind = K_IEN;
        default: s.kind = K_NONE;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/stor_addr_decode.sv
module stor_addr_decode
  import stor_regblock_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output reg_sel_t          rd_sel,
  output reg_sel_t          wr_sel,
  output logic [1:0]        tf_data_sel,
  output logic [1:0]        tf_ctl_sel,
  output logic [2:0]        tf_idx,
  output logic              tf_wr
);

  logic     hi_ok;
  reg_sel_t rd_raw;
  reg_sel_t wr_raw;
  reg_sel_t any_sel;

  generate
    if (ADDR_W > 9) begin : g_hi
      assign hi_ok = ~|bus_addr[ADDR_W-1:9];
    end else begin : g_nohi
      assign hi_ok = 1'b1;
    end
  endgenerate

  always_comb begin
    rd_raw = decode_addr(bus_addr[8:0], 1'b0);
    wr_raw = decode_addr(bus_addr[8:0], 1'b1);
    rd_sel = rd_raw;
    wr_sel = wr_raw;
    if (!(bus_rd && hi_ok)) rd_sel.kind = K_NONE;
    if (!(bus_wr && hi_ok)) wr_sel.kind = K_NONE;
  end

  // Task-file kinds decode the same way for reads and writes.
  always_comb begin
    any_sel     = bus_wr ? wr_sel : rd_sel;
    tf_data_sel = 2'b00;
    tf_ctl_sel  = 2'b00;
    if (any_sel.kind == K_TFDATA) tf_data_sel[any_sel.ch] = 1'b1;
    if (any_sel.kind == K_TFCTL)  tf_ctl_sel[any_sel.ch]  = 1'b1;
    tf_idx = any_sel.sub;
    tf_wr  = bus_wr && ((any_sel.kind == K_TFDATA) || (any_sel.kind == K_TFCTL));
  end

endmodule

// File: rtl/stor_chan_regs.sv
module stor_chan_regs
  import stor_regblock_pkg::*;
#(
  parameter int CH_ID = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  reg_sel_t           wr_sel,
  input  logic [1:0]         wr_size,
  input  logic [31:0]        wdata,
  input  logic               dma_active,
  input  logic               err_set,
  input  logic               int_set,
  input  logic               irq_in,
  output logic [7:0]         cmd_q,
  output logic [VDATA_W-1:0] vdata_q,
  output logic [7:0]         stat_q,
  output logic [31:0]        ptr_q,
  output logic [SCTL_W-1:0]  sctl_q,
  output logic [IEN_W-1:0]   ien_q,
  output logic               pend_q,
  output logic               bus_rst_q
);

  localparam int PTR_BYTES = 4;

  logic mine;
  logic wr_cmd, wr_vdata, wr_stat, wr_ptr, wr_sctl, wr_ien;
  logic [7:0]           stat_d;
  logic [31:0]          ptr_d;
  logic [31:0]          ptr_wshift;
  logic [PTR_BYTES-1:0] lane_base;
  logic [PTR_BYTES-1:0] lane_en;
  logic                 bus_rst_d;
  logic                 unused_sub;

  assign unused_sub = wr_sel.sub[2];

  assign mine     = (wr_sel.ch == CH_ID[0]);
  assign wr_cmd   = mine && (wr_sel.kind == K_CMD);
  assign wr_vdata = mine && (wr_sel.kind == K_VDATA);
  assign wr_stat  = mine && (wr_sel.kind == K_STAT);
  assign wr_ptr   = mine && (wr_sel.kind == K_PTR);
  assign wr_sctl  = mine && (wr_sel.kind == K_SCTL);
  assign wr_ien   = mine && (wr_sel.kind == K_IEN);

  // Status next state: write rule first, hardware sets override.
  always_comb begin
    stat_d    = stat_q;
    stat_d[0] = dma_active;
    if (wr_stat) begin
      stat_d[6:5] = wdata[6:5];
      stat_d[2:1] = stat_q[2:1] & ~wdata[2:1];
      stat_d[7]   = 1'b0;
      stat_d[4:3] = 2'b00;
    end
    if (err_set) stat_d[1] = 1'b1;
    if (int_set) stat_d[2] = 1'b1;
  end

  // Pointer byte lanes from access size and starting byte.
  always_comb begin
    case (wr_size)
      2'd0:    lane_base = 4'b0001;
      2'd1:    lane_base = 4'b0011;
      default: lane_base = 4'b1111;
    endcase
    lane_en    = wr_ptr ? (lane_base << wr_sel.sub[1:0]) : '0;
    ptr_wshift = wdata << {wr_sel.sub[1:0], 3'b000};
  end

  generate
    for (genvar j = 0; j < PTR_BYTES; j++) begin : g_lane
      assign ptr_d[8*j +: 8] = lane_en[j] ? ptr_wshift[8*j +: 8] : ptr_q[8*j +: 8];
    end
  endgenerate

  assign bus_rst_d = wr_sctl && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      vdata_q   <= '0;
      stat_q    <= '0;
      ptr_q     <= '0;
      sctl_q    <= '0;
      ien_q     <= '0;
      pend_q    <= 1'b0;
      bus_rst_q <= 1'b0;
    end else begin
      if (wr_cmd)   cmd_q   <= wdata[7:0];
      if (wr_vdata) vdata_q <= wdata[VDATA_W-1:0];
      if (|lane_en) ptr_q   <= ptr_d;
      if (wr_sctl)  sctl_q  <= wdata[SCTL_W-1:0];
      if (wr_ien)   ien_q   <= wdata[31:16] & IEN_MASK;
      stat_q    <= stat_d;
      pend_q    <= irq_in;
      bus_rst_q <= bus_rst_d;
    end
  end

  // R6
  sctl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sctl && wdata[0]) |=> bus_rst_q);

  // R6
  sctl_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_q |-> $past(wr_sctl && wdata[0]));

  // R4
  stat_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wdata[1] && !err_set) |=> !stat_q[1]);

  // R4
  stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_set |=> stat_q[2]);

  // R4
  stat_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stat_q[0] == $past(dma_active)));

  // R7
  ien_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ien |=> (ien_q == ($past(wdata[31:16]) & IEN_MASK)));

  // R8
  pend_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pend_q == $past(irq_in)));

  // R6
  sctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sctl |=> $stable(sctl_q));

endmodule

// File: rtl/stor_read_mux.sv
module stor_read_mux
  import stor_regblock_pkg::*;
(
  input  reg_sel_t                       rd_sel,
  input  logic [NUM_CH-1:0][7:0]         cmd,
  input  logic [NUM_CH-1:0][VDATA_W-1:0] vdata,
  input  logic [NUM_CH-1:0][7:0]         stat,
  input  logic [NUM_CH-1:0][31:0]        ptr,
  input  logic [NUM_CH-1:0][SCTL_W-1:0]  sctl,
  input  logic [NUM_CH-1:0][IEN_W-1:0]   ien,
  input  logic [NUM_CH-1:0]              pend,
  input  logic [NUM_CH-1:0]              dev_present,
  input  logic [31:0]                    tf_rdata,
  output logic [31:0]                    rdata_d
);

  logic       c;
  logic       unused_sub;
  logic [7:0] sum0_lo;
  logic [7:0] sum1_lo;

  assign c          = rd_sel.ch;
  assign unused_sub = rd_sel.sub[2];
  assign sum0_lo    = cmd[0] | {1'b0, pend[1], 1'b0, pend[0], 4'b0000};
  assign sum1_lo    = cmd[1] | {3'b000, pend[1], 4'b0000};

  always_comb begin
    case (rd_sel.kind)
      K_CMD:   rdata_d = {24'h0, cmd[c]};
      K_VDATA: rdata_d = {{(32-VDATA_W){1'b0}}, vdata[c]};
      K_STAT:  rdata_d = {24'h0, stat[c]};
      K_PTR:   rdata_d = ptr[c] >> {rd_sel.sub[1:0], 3'b000};
      K_SUM:   rdata_d = c ? {8'h00, stat[1], 8'h00, sum1_lo}
                           : {stat[1], stat[0], 1'b0, stat[1][2], 6'b000000, sum0_lo};
      K_CONF:  rdata_d = {CONF_ID, 4'b0000, pend[c], 11'h000};
      K_SCTL:  rdata_d = {{(32-SCTL_W){1'b0}}, sctl[c]};
      K_DEVST: rdata_d = dev_present[c] ? DEV_PRES_VAL : 32'h0;
      K_IEN:   rdata_d = {ien[c], 16'h0000};
      K_TFDATA,
      K_TFCTL: rdata_d = tf_rdata;
      default: rdata_d = 32'h0;
    endcase
  end

endmodule

// File: rtl/stor_regblock.sv
module stor_regblock
  import stor_regblock_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [1:0]        dma_active,
  input  logic [1:0]        dma_err_set,
  input  logic [1:0]        dma_int_set,
  input  logic [1:0]        chan_irq,
  input  logic [1:0]        dev_present,
  input  logic [31:0]       tf_rdata,
  output logic [1:0]        tf_data_sel,
  output logic [1:0]        tf_ctl_sel,
  output logic [2:0]        tf_idx,
  output logic              tf_wr,
  output logic [1:0]        chan_reset,
  output logic              irq_out
);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  reg_sel_t   rd_sel;
  reg_sel_t   wr_sel;
  logic [31:0] rdata_d;

  logic [NUM_CH-1:0][7:0]         cmd_v;
  logic [NUM_CH-1:0][VDATA_W-1:0] vdata_v;
  logic [NUM_CH-1:0][7:0]         stat_v;
  logic [NUM_CH-1:0][31:0]        ptr_v;
  logic [NUM_CH-1:0][SCTL_W-1:0]  sctl_v;
  logic [NUM_CH-1:0][IEN_W-1:0]   ien_v;
  logic [NUM_CH-1:0]              pend_v;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  stor_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .rd_sel      (rd_sel),
    .wr_sel      (wr_sel),
    .tf_data_sel (tf_data_sel),
    .tf_ctl_sel  (tf_ctl_sel),
    .tf_idx      (tf_idx),
    .tf_wr       (tf_wr)
  );

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      stor_chan_regs #(.CH_ID(i)) u_chan (
        .clk        (clk),
        .rst_n      (rst_sync_n),
        .wr_sel     (wr_sel),
        .wr_size    (bus_size),
        .wdata      (bus_wdata),
        .dma_active (dma_active[i]),
        .err_set    (dma_err_set[i]),
        .int_set    (dma_int_set[i]),
        .irq_in     (chan_irq[i]),
        .cmd_q      (cmd_v[i]),
        .vdata_q    (vdata_v[i]),
        .stat_q     (stat_v[i]),
        .ptr_q      (ptr_v[i]),
        .sctl_q     (sctl_v[i]),
        .ien_q      (ien_v[i]),
        .pend_q     (pend_v[i]),
        .bus_rst_q  (chan_reset[i])
      );
    end
  endgenerate

  stor_read_mux u_rmux (
    .rd_sel      (rd_sel),
    .cmd         (cmd_v),
    .vdata       (vdata_v),
    .stat        (stat_v),
    .ptr         (ptr_v),
    .sctl        (sctl_v),
    .ien         (ien_v),
    .pend        (pend_v),
    .dev_present (dev_present),
    .tf_rdata    (tf_rdata),
    .rdata_d     (rdata_d)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  bus_rdata <= '0;
    else if (bus_rd)  bus_rdata <= rdata_d;
  end

  assign irq_out = |pend_v;

  // R11
  irq_merge_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (irq_out == $past(|chan_irq)));

  // R13
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/stor_regblock_test.sv
module stor_regblock_test;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [1:0]  bus_size = 2'd2;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  dma_active = '0;
  logic [1:0]  dma_err_set = '0;
  logic [1:0]  dma_int_set = '0;
  logic [1:0]  chan_irq = '0;
  logic [1:0]  dev_present = '0;
  logic [31:0] tf_rdata = '0;
  logic [1:0]  tf_data_sel;
  logic [1:0]  tf_ctl_sel;
  logic [2:0]  tf_idx;
  logic        tf_wr;
  logic [1:0]  chan_reset;
  logic        irq_out;

  int n_chk = 0;
  int n_fail = 0;
  sb_item_t sb_q[$];
  sb_item_t sb_cur;
  logic rd_pending = 1'b0;

  always #5 clk = ~clk;

  stor_regblock uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dma_active(dma_active), .dma_err_set(dma_err_set), .dma_int_set(dma_int_set),
    .chan_irq(chan_irq), .dev_present(dev_present), .tf_rdata(tf_rdata),
    .tf_data_sel(tf_data_sel), .tf_ctl_sel(tf_ctl_sel), .tf_idx(tf_idx),
    .tf_wr(tf_wr), .chan_reset(chan_reset), .irq_out(irq_out)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: read data is registered at the read edge, compared on the next falling edge.
  always @(posedge clk) rd_pending <= bus_rd;
  always @(negedge clk) begin
    if (rd_pending) begin
      if (sb_q.size() == 0) chk(32'h1, 32'h0, "scoreboard underflow");
      else begin
        sb_cur = sb_q.pop_front();
        chk(bus_rdata, sb_cur.exp, sb_cur.tag);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_wr(input logic [8:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd2);
    bus_addr = a; bus_wdata = d; bus_size = sz; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [8:0] a, input logic [31:0] exp, input string tag,
                       input logic [1:0] sz = 2'd2);
    sb_item_t it;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    bus_addr = a; bus_size = sz; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_test();
  end

  initial begin
    idle(4);
    // R1: outputs while reset is held
    chk(bus_rdata, 32'h0, "R1 rdata in reset");
    chk({30'h0, chan_reset}, 32'h0, "R1 chan_reset in reset");
    chk({31'h0, irq_out}, 32'h0, "R1 irq_out in reset");
    rst_n = 1'b1;
    idle(3);
    do_rd(9'h000, 32'h0, "R1 cmd0");
    do_rd(9'h002, 32'h0, "R1 stat0");
    do_rd(9'h004, 32'h0, "R1 ptr0");
    do_rd(9'h100, 32'h0, "R1 sctl0");
    do_rd(9'h1C8, 32'h0, "R1 ien1");
    do_rd(9'h0A0, 32'h6515_0000, "R1 conf0");
    do_rd(9'h0E0, 32'h6515_0000, "R1 conf1");

    // R2 command bytes and aliases
    do_wr(9'h000, 32'h0000_00A5);
    do_rd(9'h000, 32'h0000_00A5, "R2 cmd0 base");
    do_wr(9'h018, 32'hFFFF_FF2C);
    do_rd(9'h008, 32'h0000_002C, "R2 cmd1 alias");
    do_wr(9'h010, 32'h0000_00A5);
    do_rd(9'h000, 32'h0000_00A5, "R2 cmd0 alias");

    // R3 scratch byte keeps six bits
    do_wr(9'h001, 32'h0000_00FF);
    do_rd(9'h001, 32'h0000_003F, "R3 vdata0");
    do_wr(9'h019, 32'h0000_00C5);
    do_rd(9'h009, 32'h0000_0005, "R3 vdata1 alias");

    // R4 status rule on channel 0
    dma_err_set = 2'b01; dma_int_set = 2'b01;
    idle(1);
    dma_err_set = 2'b00; dma_int_set = 2'b00;
    do_rd(9'h002, 32'h0000_0006, "R4 set pulses");
    do_wr(9'h012, 32'h0000_0062);
    do_rd(9'h002, 32'h0000_0064, "R4 w1c bit1, load 6:5");
    dma_active = 2'b01;
    idle(1);
    do_rd(9'h002, 32'h0000_0065, "R4 busy bit follows input");
    do_wr(9'h002, 32'h0000_0000);
    do_rd(9'h002, 32'h0000_0005, "R4 bit0 ignores write");
    // set and clear of bit 2 at the same edge: set wins
    dma_int_set = 2'b01;
    do_wr(9'h002, 32'h0000_0004);
    dma_int_set = 2'b00;
    do_rd(9'h002, 32'h0000_0005, "R4 set beats clear");
    do_wr(9'h002, 32'h0000_009C);
    do_rd(9'h002, 32'h0000_0001, "R4 w1c bit2, bits 7,4,3 zero");
    // channel 1 via alias 0x1A
    dma_int_set = 2'b10;
    idle(1);
    dma_int_set = 2'b00;
    do_wr(9'h01A, 32'h0000_0020);
    do_rd(9'h00A, 32'h0000_0024, "R4 ch1 alias write");

    // R5 descriptor pointer
    do_wr(9'h004, 32'h1122_3344);
    do_rd(9'h004, 32'h1122_3344, "R5 word");
    do_wr(9'h006, 32'hFFFF_FFAB, 2'd0);
    do_rd(9'h004, 32'h11AB_3344, "R5 byte lane 2");
    do_rd(9'h006, 32'h0000_11AB, "R5 read at byte 2");
    do_wr(9'h00D, 32'h1234_BEEF, 2'd1);
    do_rd(9'h00C, 32'h00BE_EF00, "R5 half at byte 1 ch1");

    // R6 link control and reset pulse
    do_wr(9'h100, 32'hFFFF_F001);
    chk({30'h0, chan_reset}, 32'h1, "R6 pulse high after write");
    idle(1);
    chk({30'h0, chan_reset}, 32'h0, "R6 pulse one clock");
    do_rd(9'h100, 32'h0000_0001, "R6 sctl0 12 bits");
    do_wr(9'h180, 32'h0000_0ABE);
    chk({30'h0, chan_reset}, 32'h0, "R6 no pulse with bit0 clear");
    do_rd(9'h180, 32'h0000_0ABE, "R6 sctl1");

    // R7 interrupt enable
    do_wr(9'h148, 32'hFFFF_1234);
    do_rd(9'h148, 32'h3EED_0000, "R7 ien0 mask");
    do_wr(9'h1C8, 32'h1234_0000);
    do_rd(9'h1C8, 32'h1224_0000, "R7 ien1 mask");

    // R8 / R11 pending interrupts
    chan_irq = 2'b01;
    idle(1);
    chk({31'h0, irq_out}, 32'h1, "R11 irq from ch0");
    do_wr(9'h0A0, 32'hFFFF_FFFF);
    do_rd(9'h0A0, 32'h6515_0800, "R8 conf0 pending, write ignored");
    do_rd(9'h0E0, 32'h6515_0000, "R8 conf1 idle");
    chan_irq = 2'b10;
    idle(1);
    chk({31'h0, irq_out}, 32'h1, "R11 irq from ch1");
    chan_irq = 2'b00;
    idle(1);
    chk({31'h0, irq_out}, 32'h0, "R11 irq clear");

    // R9 / R10 summary words
    do_rd(9'h010, 32'h2401_40A5, "R9 summary0 no pending");
    chan_irq = 2'b11;
    idle(1);
    do_rd(9'h010, 32'h2401_40F5, "R9 summary0 pending both");
    do_rd(9'h018, 32'h0024_003C, "R10 summary1 pending");
    chan_irq = 2'b00;

    // R12 device status
    dev_present = 2'b10;
    do_rd(9'h104, 32'h0, "R12 ch0 absent");
    do_rd(9'h184, 32'h0000_0113, "R12 ch1 present");

    // R13 unmapped offsets
    do_rd(9'h003, 32'h0, "R13 0x03");
    do_rd(9'h00B, 32'h0, "R13 0x0B");
    do_rd(9'h011, 32'h0, "R13 0x11 read");
    do_rd(9'h1FC, 32'h0, "R13 0x1FC");
    do_wr(9'h003, 32'hFFFF_FFFF);
    do_wr(9'h040, 32'hFFFF_FFFF);
    do_wr(9'h104, 32'hFFFF_FFFF);
    do_rd(9'h000, 32'h0000_00A5, "R13 cmd0 untouched");
    do_rd(9'h001, 32'h0000_003F, "R13 vdata0 untouched");
    do_rd(9'h002, 32'h0000_0001, "R13 stat0 untouched");

    // R14 task-file strobes
    tf_rdata = 32'h0000_CAFE;
    begin
      sb_item_t it;
      it.exp = 32'h0000_CAFE; it.tag = "R14 tf read data";
      sb_q.push_back(it);
      bus_addr = 9'h083; bus_rd = 1'b1;
      #1;
      chk({30'h0, tf_data_sel}, 32'h1, "R14 data sel ch0");
      chk({29'h0, tf_idx}, 32'h3, "R14 index");
      chk({31'h0, tf_wr}, 32'h0, "R14 read not write");
      @(negedge clk);
      bus_rd = 1'b0;
    end
    bus_addr = 9'h0CA; bus_wr = 1'b1;
    #1;
    chk({30'h0, tf_ctl_sel}, 32'h2, "R14 ctl sel ch1");
    chk({29'h0, tf_idx}, 32'h2, "R14 ctl index");
    chk({31'h0, tf_wr}, 32'h1, "R14 write flag");
    @(negedge clk);
    bus_wr = 1'b0;
    bus_addr = 9'h088; bus_rd = 1'b1;
    #1;
    chk({28'h0, tf_ctl_sel, tf_data_sel}, 32'h0, "R14 no sel at 0x88");
    sb_q.push_back('{32'h0, "R13 0x88"});
    @(negedge clk);
    bus_rd = 1'b0;

    idle(3);
    chk(sb_q.size(), 32'h0, "scoreboard drained");
    finish_test();
  end

endmodule